// File: doc/BRIEF.md
# Column Conversion Result Sorter

This block gathers 8-bit conversion results from a bank of column channels, where each channel owns two converters that take turns on even and odd row slots. Results arrive in any order, each tagged with its channel index, its slot parity and a sample index. The block stores them in one bank per parity. When a slot is started, it plays that bank out as a frame: a single marker word followed by one word per channel in ascending channel order.

A mode input picks plain single sampling, which is the default after reset, or a correlated mode. In the correlated mode each output word is the second sample minus the first, clamped at zero. The block also keeps a 2-bit pedestal compensation code for each channel. The downstream processor shifts the codes in serially and transfers them to the front-end control outputs with a load strobe.

Both data paths use valid/ready. The input stalls (`in_ready` low) only while a frame is being played out of the same parity bank that the offered result targets, and the offered result is then held by the sender. The output word, together with its marker flag, is held unchanged while `out_ready` is low, and it advances only on a handshake.

Top module: `adc_reorder`

## Requirements
- R1: After reset, out_valid is 0, seq_err is 0, ped_code is all zeros, and the mode is single sampling.
- R2: A result is accepted on a cycle with in_valid and in_ready both high. in_ready is low exactly when a frame is playing out of the bank whose parity equals in_par.
- R3: A slot_go pulse while idle starts a frame for the bank selected by slot_par. The frame is one word with out_frame=1 and out_data=0x00, then NCH words with out_frame=0 for channels 0, 1, ..., NCH-1. A slot_go that arrives while a frame is running is ignored.
- R4: While out_valid is high and out_ready is low, out_valid, out_frame and out_data stay unchanged.
- R5: In single mode (dcs_mode=0 at slot_go), a channel's word is the last result written with in_samp=0 to that channel and parity.
- R6: In correlated mode (dcs_mode=1 at slot_go), a channel's word is the in_samp=1 result minus the in_samp=0 result. When that difference is negative, the word is 0x00.
- R7: The mode is captured at slot_go. Changing dcs_mode during a frame does not alter that frame.
- R8: If a channel lacks a needed result when its word is handed over, the word is 0x00 and seq_err goes high. seq_err stays high until reset.
- R9: Handing over a channel's word clears both stored results of that channel in that parity bank.
- R10: Each cycle with ped_shift high shifts ped_sin in. After 2*NCH shifts, the first bit sent becomes bit 0 of ped_code, and channel c's code sits at ped_code[2c+1:2c]. ped_code changes only on a cycle with ped_load high, when it takes the shifted contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dcs_mode | input | 1 | 1 = correlated difference mode, 0 = single sampling |
| in_valid | input | 1 | Result offered |
| in_ready | output | 1 | Result can be taken |
| in_chan | input | $clog2(NCH) | Channel index of the result |
| in_par | input | 1 | Slot parity, which selects the converter/bank |
| in_samp | input | 1 | Sample index: 0 first, 1 second |
| in_data | input | 8 | Conversion result |
| slot_go | input | 1 | Start a frame |
| slot_par | input | 1 | Parity bank to play out |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_frame | output | 1 | Word is the frame marker |
| out_data | output | 8 | Sorted channel word |
| seq_err | output | 1 | Sticky missing-result flag |
| ped_sin | input | 1 | Serial pedestal code bit |
| ped_shift | input | 1 | Shift enable for ped_sin |
| ped_load | input | 1 | Transfer shifted codes to ped_code |
| ped_code | output | 2*NCH | Per-channel 2-bit pedestal codes |

## Verification
Assertions check the following on every cycle: a frame opens with its marker, a stalled output word holds still, a result write never meets an entry clear in the same bank, the error flag stays set, and the pedestal outputs move only on a load. The bench scenarios are the only place that shows the sorted order after a scrambled fill, the clamped correlated difference, the zero words and error for missing channels, the clearing of consumed entries, the mode capture, the ignored mid-frame start, and the serial bit order of the pedestal codes.

// File: rtl/adc_sort_pkg.sv
package adc_sort_pkg;
  parameter int SAMPLE_W = 8;
  typedef logic [SAMPLE_W-1:0] sample_t;

  // second minus first, clamped at zero
  function automatic sample_t clamp_diff(input sample_t first, input sample_t second);
    return (second >= first) ? sample_t'(second - first) : '0;
  endfunction
endpackage

// File: rtl/adc_ped_chain.sv
module adc_ped_chain #(
  parameter int NCH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sin,
  input  logic             shift,
  input  logic             load,
  output logic [2*NCH-1:0] code
);
  localparam int BITS = 2 * NCH;
  logic [BITS-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      code <= '0;
    end else begin
      if (shift) sreg <= {sin, sreg[BITS-1:1]};
      if (load)  code <= sreg;
    end
  end

  AST_PED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(code)); // R10
endmodule

// File: rtl/adc_sample_bank.sv
module adc_sample_bank
  import adc_sort_pkg::*;
#(
  parameter int NCH = 256,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wch,
  input  logic          wsamp,
  input  sample_t       wdata,
  input  logic          clr,
  input  logic [CW-1:0] cch,
  input  logic [CW-1:0] rch,
  output sample_t       rd_first,
  output sample_t       rd_second,
  output logic          have_first,
  output logic          have_second
);
  sample_t        first_q  [NCH];
  sample_t        second_q [NCH];
  logic [NCH-1:0] vf, vs;

  always_ff @(posedge clk) begin
    if (we) begin
      if (wsamp) second_q[wch] <= wdata;
      else       first_q[wch]  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vf <= '0;
      vs <= '0;
    end else begin
      if (clr) begin
        vf[cch] <= 1'b0;
        vs[cch] <= 1'b0;
      end
      if (we) begin
        if (wsamp) vs[wch] <= 1'b1;
        else       vf[wch] <= 1'b1;
      end
    end
  end

  assign rd_first    = first_q[rch];
  assign rd_second   = second_q[rch];
  assign have_first  = vf[rch];
  assign have_second = vs[rch];

  AST_NO_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && clr)); // R2
endmodule

// File: rtl/adc_reorder.sv
module adc_reorder
  import adc_sort_pkg::*;
#(
  parameter int NCH = 256,
  localparam int CW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dcs_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CW-1:0]    in_chan,
  input  logic             in_par,
  input  logic             in_samp,
  input  logic [7:0]       in_data,
  input  logic             slot_go,
  input  logic             slot_par,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_frame,
  output logic [7:0]       out_data,
  output logic             seq_err,
  input  logic             ped_sin,
  input  logic             ped_shift,
  input  logic             ped_load,
  output logic [2*NCH-1:0] ped_code
);
  logic          busy, marker, cur_par, mode_q;
  logic [CW-1:0] cnt;
  logic          in_fire, out_fire, word_fire;

  sample_t rf [2];
  sample_t rs [2];
  logic [1:0] hf, hs;

  assign in_ready  = !(busy && (in_par == cur_par));
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign word_fire = out_fire && !marker;

  for (genvar p = 0; p < 2; p++) begin : g_bank
    adc_sample_bank #(.NCH(NCH)) i_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (in_fire && (in_par == p[0])),
      .wch        (in_chan),
      .wsamp      (in_samp),
      .wdata      (in_data),
      .clr        (word_fire && (cur_par == p[0])),
      .cch        (cnt),
      .rch        (cnt),
      .rd_first   (rf[p]),
      .rd_second  (rs[p]),
      .have_first (hf[p]),
      .have_second(hs[p])
    );
  end

  logic    hit;
  sample_t word;
  always_comb begin
    hit  = mode_q ? (hf[cur_par] && hs[cur_par]) : hf[cur_par];
    word = mode_q ? clamp_diff(rf[cur_par], rs[cur_par]) : rf[cur_par];
  end

  assign out_valid = busy;
  assign out_frame = busy && marker;
  assign out_data  = (busy && !marker && hit) ? word : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      marker  <= 1'b0;
      cur_par <= 1'b0;
      mode_q  <= 1'b0;
      cnt     <= '0;
      seq_err <= 1'b0;
    end else if (!busy) begin
      if (slot_go) begin
        busy    <= 1'b1;
        marker  <= 1'b1;
        cur_par <= slot_par;
        mode_q  <= dcs_mode;
        cnt     <= '0;
      end
    end else if (out_fire) begin
      if (marker) begin
        marker <= 1'b0;
      end else begin
        if (!hit) seq_err <= 1'b1;
        if (cnt == CW'(NCH - 1)) busy <= 1'b0;
        else                     cnt  <= cnt + 1'b1;
      end
    end
  end

  adc_ped_chain #(.NCH(NCH)) i_ped (
    .clk  (clk),
    .rst_n(rst_n),
    .sin  (ped_sin),
    .shift(ped_shift),
    .load (ped_load),
    .code (ped_code)
  );

  AST_FRAME_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_frame); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_frame))); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err); // R8
endmodule

// File: tb/test_adc_reorder.sv
module test_adc_reorder;
  localparam int NCH = 256;
  localparam int CW  = $clog2(NCH);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, dcs_mode, in_valid, in_ready, in_par, in_samp;
  logic [CW-1:0] in_chan;
  logic [7:0] in_data, out_data;
  logic slot_go, slot_par, out_valid, out_ready, out_frame, seq_err;
  logic ped_sin, ped_shift, ped_load;
  logic [2*NCH-1:0] ped_code;

  adc_reorder #(.NCH(NCH)) i_adc_reorder (.*);

  int checks = 0, errors = 0;
  bit rdy_stall = 1'b0;
  logic [8:0] exp_q [$];
  string      req_q [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit frm, input logic [7:0] d, input string req);
    exp_q.push_back({frm, d});
    req_q.push_back(req);
  endtask

  // driver for results
  task automatic put(input bit par, input bit samp, input int ch, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_par = par; in_samp = samp; in_chan = CW'(ch); in_data = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic go(input bit par);
    @(negedge clk);
    slot_go = 1'b1; slot_par = par;
    @(negedge clk);
    slot_go = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R3 frame ends", out_valid, 0);
  endtask

  // monitor: compares handed-over words with the scoreboard
  int cyc = 0;
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = rdy_stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected word", {out_frame, out_data}, 0);
        end else begin
          logic [8:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check({out_frame, out_data} == e, r, {out_frame, out_data}, e);
        end
      end
    end
  end

  bit finished = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dcs_mode = 1'b0; in_valid = 1'b0; in_par = 1'b0; in_samp = 1'b0;
    in_chan = '0; in_data = '0; slot_go = 1'b0; slot_par = 1'b0;
    ped_sin = 1'b0; ped_shift = 1'b0; ped_load = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(seq_err == 1'b0, "R1 seq_err", seq_err, 0);
    check(ped_code == '0, "R1 ped_code", 0, 0);

    // single mode, parity 0, scrambled fill; default mode after reset (R1, R5)
    for (int i = 0; i < NCH; i++) begin
      int ch;
      ch = (i * 37 + 11) % NCH;
      put(1'b0, 1'b0, ch, 8'(ch) ^ 8'h5A);
    end
    push(1'b1, 8'h00, "R3 marker");
    for (int c = 0; c < NCH; c++) push(1'b0, 8'(c) ^ 8'h5A, "R5 R3 sorted single word");
    rdy_stall = 1'b1;
    go(1'b0);
    // input to the bank being played out must stall (R2)
    @(negedge clk);
    in_valid = 1'b1; in_par = 1'b0; in_samp = 1'b0; in_chan = '0;
    #1;
    check(in_ready == 1'b0, "R2 stall same parity", in_ready, 0);
    in_par = 1'b1;
    #1;
    check(in_ready == 1'b1, "R2 other parity open", in_ready, 1);
    in_valid = 1'b0;
    drain();
    check(seq_err == 1'b0, "R8 no error when complete", seq_err, 0);

    // correlated mode, parity 1 (R6, R7); mid-frame start ignored (R3)
    for (int c = NCH - 1; c >= 0; c--) begin
      put(1'b1, 1'b1, c, 8'((c + 40) % 256));
      put(1'b1, 1'b0, c, 8'(c));
    end
    push(1'b1, 8'h00, "R3 marker");
    for (int c = 0; c < NCH; c++)
      push(1'b0, (c + 40 < 256) ? 8'd40 : 8'h00, "R6 R7 clamped difference");
    dcs_mode = 1'b1;
    go(1'b1);
    dcs_mode = 1'b0;
    repeat (20) @(negedge clk);
    go(1'b0);
    drain();
    check(seq_err == 1'b0, "R8 no error dcs", seq_err, 0);

    // missing channels, parity 0 after it was consumed (R8, R9)
    for (int c = 0; c < NCH; c += 2) put(1'b0, 1'b0, c, 8'(c) ^ 8'h5A);
    push(1'b1, 8'h00, "R3 marker");
    for (int c = 0; c < NCH; c++)
      push(1'b0, (c % 2 == 0) ? (8'(c) ^ 8'h5A) : 8'h00, "R8 R9 missing gives zero");
    rdy_stall = 1'b0;
    go(1'b0);
    drain();
    check(seq_err == 1'b1, "R8 error set", seq_err, 1);
    repeat (5) @(negedge clk);
    check(seq_err == 1'b1, "R8 error sticky", seq_err, 1);

    // pedestal chain (R10): channel c gets code c%4, bit 0 sent first
    for (int k = 0; k < 2 * NCH; k++) begin
      @(negedge clk);
      ped_shift = 1'b1;
      ped_sin = ((k / 2) % 4) >> (k % 2);
    end
    @(negedge clk);
    ped_shift = 1'b0;
    repeat (2) @(negedge clk);
    check(ped_code == '0, "R10 no change before load", 0, 0);
    ped_load = 1'b1;
    @(negedge clk);
    ped_load = 1'b0;
    #1;
    begin
      int bad;
      bad = 0;
      for (int c = 0; c < NCH; c++) if (ped_code[2*c +: 2] != 2'(c % 4)) bad++;
      check(bad == 0, "R10 loaded codes", bad, 0);
    end
    check(ped_code[7:0] == 8'hE4, "R10 low bits", ped_code[7:0], 8'hE4);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule